// File: doc/BRIEF.md
# Idle-Mode Clock Sequencer

This block sequences a small processor between a running state and an idle state. In the idle state the processor clock is gated off and the peripheral clock keeps running. The peripheral clock runs from whichever oscillator the two-bit clock-select input names when the sleep strobe arrives. Selecting the secondary oscillator turns the primary oscillator off and moves the two running-status flags to match. Any other select value keeps the primary oscillator on.

A wake event does not reopen the processor clock straight away. It starts a settling counter of `SETTLE_CYC` cycles, and a further wake during that count restarts it. When the count ends, the processor resumes on the oscillator the peripherals were using. The block never drives the idle-enable or clock-select controls. It only samples them. A sleep strobe that arrives while idle-enable is clear asks for the deeper, fully stopped sleep. That request is handled elsewhere, so this block only reports it as a one-cycle pulse.

Every output comes from a register. The clock enables therefore change only at a clock edge and stay glitch-free when they feed a clock gate.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After synchronous reset the outputs are: `cpu_clk_en`=1, `per_clk_en`=1, `clk_src`=2'b00 (primary), `pri_osc_en`=1, `pri_running`=1, `sec_running`=0, `full_sleep_req`=0.
- R2: While running, `clk_sel`=2'b01 gives `clk_src`=2'b01 (secondary), `pri_osc_en`=0, `pri_running`=0 and `sec_running`=1. Every other `clk_sel` value gives `clk_src`=2'b00 with those three flags inverted. The change appears one edge after the select is sampled.
- R3: A sleep strobe with `idle_en`=1 while running clears `cpu_clk_en` at the edge that samples it. `per_clk_en` stays 1.
- R4: In idle or settling on the primary source, `pri_osc_en` and `pri_running` stay 1.
- R5: In idle or settling on the secondary source, and on resuming from it, `sec_running`=1 and `pri_osc_en`=0.
- R6: While idle or settling, changes on `clk_sel` and wake events leave `clk_src` unchanged.
- R7: After a wake in idle, `cpu_clk_en` becomes 1 on exactly the `SETTLE_CYC`-th rising edge after the edge that sampled the wake, and not earlier.
- R8: A wake during settling restarts the count. `cpu_clk_en` then rises `SETTLE_CYC` edges after the later wake.
- R9: On the edge where `cpu_clk_en` returns to 1, `clk_src` equals the source used during idle.
- R10: A sleep strobe with `idle_en`=0 while running gives `full_sleep_req`=1 for exactly one cycle. `cpu_clk_en` stays 1.
- R11: A sleep strobe while idle or settling is ignored. `full_sleep_req` stays 0 and the settling timing is unchanged.
- R12: A wake event while running is ignored. `cpu_clk_en` stays 1 and `clk_src` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe |
| idle_en | input | 1 | Idle-enable control bit |
| clk_sel | input | 2 | System clock-select field (01 = secondary) |
| wake | input | 1 | Wake event |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| clk_src | output | 2 | Selected source, 00 primary, 01 secondary |
| pri_running | output | 1 | Primary-oscillator-running flag |
| sec_running | output | 1 | Secondary-oscillator-running flag |
| full_sleep_req | output | 1 | One-cycle request for full sleep |

## Verification
A wrong mode state shows up on `cpu_clk_en` at the very next edge. That includes a missed idle entry, idle entered from the wrong state, or a resume that never happens. A counter that is off by one moves the resume edge, and the bench checks `cpu_clk_en` on every edge of the settling window to catch that. A source register that is not frozen shows up on `clk_src` and the status flags within one cycle of a select change made during idle. A missed reload shows up as an early resume after the second wake.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_IDLE   = 2'b01,
    MODE_SETTLE = 2'b10
  } pm_mode_e;

  typedef enum logic [1:0] {
    SRC_PRI = 2'b00,
    SRC_SEC = 2'b01
  } clk_src_e;

  localparam logic [1:0] SEL_SEC = 2'b01;
endpackage

// File: rtl/idle_settle_timer.sv
module idle_settle_timer #(
  parameter int unsigned SETTLE_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= RELOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CW'(1));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == RELOAD));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/idle_mode_fsm.sv
module idle_mode_fsm
  import idle_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sleep_stb,
  input  logic     idle_en,
  input  logic     wake,
  input  logic     expire,
  output pm_mode_e mode_q,
  output logic     timer_load,
  output logic     cpu_clk_en,
  output logic     per_clk_en,
  output logic     full_sleep_req
);
  pm_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:    if (sleep_stb && idle_en) mode_d = MODE_IDLE;
      MODE_IDLE:   if (wake) mode_d = MODE_SETTLE;
      MODE_SETTLE: if (wake) mode_d = MODE_SETTLE;
                   else if (expire) mode_d = MODE_RUN;
      default:     mode_d = MODE_RUN;
    endcase
  end

  assign timer_load = wake && (mode_q != MODE_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q         <= MODE_RUN;
      cpu_clk_en     <= 1'b1;
      per_clk_en     <= 1'b1;
      full_sleep_req <= 1'b0;
    end else begin
      mode_q         <= mode_d;
      cpu_clk_en     <= (mode_d == MODE_RUN);
      per_clk_en     <= 1'b1;
      full_sleep_req <= (mode_q == MODE_RUN) && sleep_stb && !idle_en;
    end
  end

  // R3
  enter_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && sleep_stb && idle_en) |=> (!cpu_clk_en && per_clk_en));

  // R7
  settle_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SETTLE && !expire) |=> !cpu_clk_en);

  // R11
  no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_RUN) |=> !full_sleep_req);

  // R12
  wake_run_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && !sleep_stb && wake) |=> cpu_clk_en);

  // R10
  full_req_run_chk: assert property (@(posedge clk) disable iff (rst)
    full_sleep_req |-> cpu_clk_en);
endmodule

// File: rtl/idle_src_sel.sv
module idle_src_sel
  import idle_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pm_mode_e   mode_q,
  input  logic [1:0] clk_sel,
  output logic [1:0] clk_src,
  output logic       pri_osc_en,
  output logic       pri_running,
  output logic       sec_running
);
  clk_src_e src_q, src_d;

  always_comb begin
    if (mode_q == MODE_RUN)
      src_d = (clk_sel == SEL_SEC) ? SRC_SEC : SRC_PRI;
    else
      src_d = src_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q       <= SRC_PRI;
      pri_osc_en  <= 1'b1;
      pri_running <= 1'b1;
      sec_running <= 1'b0;
    end else begin
      src_q       <= src_d;
      pri_osc_en  <= (src_d == SRC_PRI);
      pri_running <= (src_d == SRC_PRI);
      sec_running <= (src_d == SRC_SEC);
    end
  end

  assign clk_src = src_q;

  // R6
  frozen_src_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_RUN) |=> $stable(clk_src));

  // R2
  one_osc_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({pri_running, sec_running}) == 1);

  // R5
  pri_off_chk: assert property (@(posedge clk) disable iff (rst)
    sec_running |-> !pri_osc_en);
endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl
  import idle_clk_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_stb,
  input  logic       idle_en,
  input  logic [1:0] clk_sel,
  input  logic       wake,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       pri_osc_en,
  output logic [1:0] clk_src,
  output logic       pri_running,
  output logic       sec_running,
  output logic       full_sleep_req
);
  pm_mode_e mode_q;
  logic     timer_load;
  logic     expire;

  idle_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (timer_load),
    .expire (expire)
  );

  idle_mode_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .sleep_stb      (sleep_stb),
    .idle_en        (idle_en),
    .wake           (wake),
    .expire         (expire),
    .mode_q         (mode_q),
    .timer_load     (timer_load),
    .cpu_clk_en     (cpu_clk_en),
    .per_clk_en     (per_clk_en),
    .full_sleep_req (full_sleep_req)
  );

  idle_src_sel u_src (
    .clk         (clk),
    .rst         (rst),
    .mode_q      (mode_q),
    .clk_sel     (clk_sel),
    .clk_src     (clk_src),
    .pri_osc_en  (pri_osc_en),
    .pri_running (pri_running),
    .sec_running (sec_running)
  );
endmodule

// File: tb/test_idle_clk_ctrl.sv
`timescale 1ns/100ps
module test_idle_clk_ctrl;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_stb = 1'b0, idle_en = 1'b0, wake = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic cpu_clk_en, per_clk_en, pri_osc_en, pri_running, sec_running, full_sleep_req;
  logic [1:0] clk_src;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  idle_clk_ctrl #(.SETTLE_CYC(N)) i_idle_clk_ctrl (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .idle_en(idle_en),
    .clk_sel(clk_sel), .wake(wake), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .pri_osc_en(pri_osc_en), .clk_src(clk_src),
    .pri_running(pri_running), .sec_running(sec_running),
    .full_sleep_req(full_sleep_req)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_src(string tag, logic sec);
    check({tag, " clk_src"}, 32'(clk_src), sec ? 32'd1 : 32'd0);
    check({tag, " pri_osc_en"}, 32'(pri_osc_en), 32'(!sec));
    check({tag, " pri_running"}, 32'(pri_running), 32'(!sec));
    check({tag, " sec_running"}, 32'(sec_running), 32'(sec));
  endtask

  task automatic enter_idle();
    idle_en = 1'b1; sleep_stb = 1'b1; tick(); sleep_stb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    // R1 reset state
    check("R1 cpu_clk_en", 32'(cpu_clk_en), 1);
    check("R1 per_clk_en", 32'(per_clk_en), 1);
    check("R1 full_sleep_req", 32'(full_sleep_req), 0);
    check_src("R1", 1'b0);

    // R2 run-mode source sweep
    for (int s = 0; s < 4; s++) begin
      clk_sel = 2'(s); tick();
      check_src("R2", s == 1);
    end

    // idle / wake sweep over every select value
    for (int s = 0; s < 4; s++) begin
      logic sec;
      sec = (s == 1);
      clk_sel = 2'(s); tick();
      enter_idle();
      check("R3 cpu_clk_en", 32'(cpu_clk_en), 0);
      check("R3 per_clk_en", 32'(per_clk_en), 1);
      check_src(sec ? "R5 idle" : "R4 idle", sec);
      clk_sel = 2'(s ^ 1);
      for (int k = 0; k < 3; k++) begin
        tick();
        check_src("R6 frozen", sec);
      end
      sleep_stb = 1'b1; tick(); sleep_stb = 1'b0;
      check("R11 idle full_sleep_req", 32'(full_sleep_req), 0);
      check("R11 idle cpu_clk_en", 32'(cpu_clk_en), 0);
      wake = 1'b1; tick(); wake = 1'b0;
      check("R7 wake edge cpu", 32'(cpu_clk_en), 0);
      for (int k = 1; k <= N; k++) begin
        if (k == 2) sleep_stb = 1'b1;
        tick();
        sleep_stb = 1'b0;
        check("R7 settle cpu_clk_en", 32'(cpu_clk_en), 32'(k == N));
        if (k == 2) check("R11 settle full_sleep_req", 32'(full_sleep_req), 0);
        if (k < N) check_src(sec ? "R5 settle" : "R4 settle", sec);
      end
      check_src(sec ? "R9 R5 resume" : "R9 resume", sec);
    end

    // R8 reload on second wake
    clk_sel = 2'b00; tick();
    enter_idle();
    wake = 1'b1; tick(); wake = 1'b0;
    repeat (3) tick();
    check("R8 before second wake", 32'(cpu_clk_en), 0);
    wake = 1'b1; tick(); wake = 1'b0;
    for (int k = 1; k <= N; k++) begin
      tick();
      check("R8 reload cpu_clk_en", 32'(cpu_clk_en), 32'(k == N));
    end

    // R10 full-sleep request
    idle_en = 1'b0; sleep_stb = 1'b1; tick(); sleep_stb = 1'b0;
    check("R10 full_sleep_req pulse", 32'(full_sleep_req), 1);
    check("R10 cpu_clk_en", 32'(cpu_clk_en), 1);
    tick();
    check("R10 full_sleep_req drop", 32'(full_sleep_req), 0);

    // R12 wake in run
    clk_sel = 2'b01; tick();
    wake = 1'b1; tick(); wake = 1'b0;
    for (int k = 0; k < N + 2; k++) begin
      check("R12 cpu_clk_en", 32'(cpu_clk_en), 1);
      check("R12 clk_src", 32'(clk_src), 1);
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule